// File: doc/BRIEF.md
# Forty-Bit Signed ALU with Split Sixteen-Bit Lanes

This block is the arithmetic and logic stage of a signal-processing data path. Each accepted request names one operation and carries two 40-bit operands (`a`, `b`), a lane-split flag, a saturation enable and a 6-bit bit index. One clock later the block presents a 40-bit result and four flags: carry, signed overflow, zero and "less than".

The arithmetic operations are add, subtract and compare. The logic operations are AND, OR, XOR and invert. There is also an absolute value, and an operation that sets or clears a single bit of `a`.

When the lane-split flag is raised, the adder breaks its carry chain at bit 16. It then works as two independent 16-bit signed adders, one on bits 15..0 and one on bits 31..16, and bits 39..32 copy the sign of the upper lane. Compare updates only the flags, so a value sitting in the result register survives a comparison.

Top module: `dalu_core`

## Requirements
- R1: Each request with `in_valid`=1 yields `out_valid`=1 on the following cycle. With `in_valid`=0, `out_valid` is 0 and the result and all flags keep their values. Reset clears the result, all flags and `out_valid` to 0.
- R2: Code 0 adds and code 1 subtracts (`a`-`b`) over the full 40 bits. `carry` is the carry out of bit 39, which for subtract means no borrow (`a` >= `b` unsigned).
- R3: `ovf` is set when the exact signed result does not fit in 40 bits. With `sat_en`=0 the result wraps modulo 2^40.
- R4: With `dual`=1 and code 0, 1 or 2, bits 15..0 and bits 31..16 are added or subtracted as separate signed 16-bit lanes with no carry between them. Bits 39..32 equal bit 31. `carry` is the carry out of the upper lane, and `ovf` is the OR of the two lane overflows.
- R5: With `sat_en`=1, an overflowing result clamps toward the sign of the exact result. In 40-bit mode it clamps to 0x7FFFFFFFFF or 0x8000000000. In lane mode each overflowing lane clamps to 0x7FFF or 0x8000.
- R6: Code 2 (compare) sets every flag as subtract would and leaves the result output unchanged.
- R7: Codes 3, 4, 5 and 6 give `a`&`b`, `a`|`b`, `a`^`b` and ~`a`, with `carry`, `ovf` and `lt` all 0.
- R8: Code 7 gives |`a|`. For `a`=0x8000000000 it sets `ovf` and returns 0x7FFFFFFFFF when `sat_en`=1, or 0x8000000000 otherwise. `carry` and `lt` are 0.
- R9: Code 8 sets and code 9 clears bit `bit_idx` of `a`. An index of 40 or more returns `a` unchanged.
- R10: `zero` is 1 when the result is 0; for compare it is 1 when the difference is 0. `lt` is the sign of the exact arithmetic result (for subtract and compare: signed `a` < `b`), taken from the upper lane in lane mode.
- R11: `dual` has no effect on codes 3 to 9. Codes 10 to 15 pass `a` through, with `carry`, `ovf` and `lt` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code |
| dual | input | 1 | Split the adder into two 16-bit lanes |
| sat_en | input | 1 | Clamp overflowing results |
| a | input | 40 | First operand |
| b | input | 40 | Second operand |
| bit_idx | input | 6 | Bit position for set and clear |
| out_valid | output | 1 | Result and flags updated by the previous request |
| result | output | 40 | Result register |
| carry | output | 1 | Carry / no-borrow flag |
| ovf | output | 1 | Signed overflow flag |
| zero | output | 1 | Zero flag |
| lt | output | 1 | Sign of the exact arithmetic result |

## Verification
Two of this block's functions can land in the same cycle.

The first pair is a compare that refreshes the flags while the result register must stay as it is. The bench follows an add with compares whose difference is zero and whose difference is negative. It then checks that `result` still holds the earlier sum while `zero` and `lt` follow the comparison.

The second pair is the two lanes in split mode, where a carry or overflow in the low lane happens together with an independent upper-lane add. Operands such as 0xFFFF in the low lane next to a small upper lane show whether a carry leaks across bit 16. A scoreboard built from an independent arithmetic model judges every result.

// File: rtl/dalu_pkg.sv
package dalu_pkg;
    localparam int DW  = 40;
    localparam int HW  = 16;
    localparam int IXW = 6;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_NOT  = 4'd6,
        OP_ABS  = 4'd7,
        OP_BSET = 4'd8,
        OP_BCLR = 4'd9
    } op_e;
endpackage

// File: rtl/dalu_arith.sv
module dalu_arith #(
    parameter int DW = 40,
    parameter int HW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  logic          dual,
    input  logic          sat,
    output logic [DW-1:0] res,
    output logic          c_out,
    output logic          v_out,
    output logic          neg
);
    localparam int TW = DW - 2*HW;
    localparam logic [DW-1:0] WMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] WMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [HW-1:0] LMAX = {1'b0, {(HW-1){1'b1}}};
    localparam logic [HW-1:0] LMIN = {1'b1, {(HW-1){1'b0}}};

    logic [DW-1:0] bx;
    logic [HW:0]   lo_s, md_s;
    logic [TW:0]   tp_s;
    logic          md_cin;
    logic [DW-1:0] wsum;
    logic          w_v, l_v, h_v;
    logic [HW-1:0] l_r, h_r;

    assign bx     = sub ? ~b : b;
    assign lo_s   = {1'b0, a[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, sub};
    // lane split: upper lane gets its own carry-in instead of bit 15's carry
    assign md_cin = dual ? sub : lo_s[HW];
    assign md_s   = {1'b0, a[2*HW-1:HW]} + {1'b0, bx[2*HW-1:HW]} + {{HW{1'b0}}, md_cin};
    assign tp_s   = {1'b0, a[DW-1:2*HW]} + {1'b0, bx[DW-1:2*HW]} + {{TW{1'b0}}, md_s[HW]};
    assign wsum   = {tp_s[TW-1:0], md_s[HW-1:0], lo_s[HW-1:0]};

    assign w_v = (a[DW-1] == bx[DW-1]) && (wsum[DW-1] != a[DW-1]);
    assign l_v = (a[HW-1] == bx[HW-1]) && (lo_s[HW-1] != a[HW-1]);
    assign h_v = (a[2*HW-1] == bx[2*HW-1]) && (md_s[HW-1] != a[2*HW-1]);

    assign l_r = (sat && l_v) ? (a[HW-1]   ? LMIN : LMAX) : lo_s[HW-1:0];
    assign h_r = (sat && h_v) ? (a[2*HW-1] ? LMIN : LMAX) : md_s[HW-1:0];

    always_comb begin
        if (dual) begin
            res   = {{TW{h_r[HW-1]}}, h_r, l_r};
            c_out = md_s[HW];
            v_out = l_v | h_v;
            neg   = md_s[HW-1] ^ h_v;
        end else begin
            res   = (sat && w_v) ? (a[DW-1] ? WMIN : WMAX) : wsum;
            c_out = tp_s[TW];
            v_out = w_v;
            neg   = wsum[DW-1] ^ w_v;
        end
    end
endmodule

// File: rtl/dalu_unary.sv
module dalu_unary
    import dalu_pkg::*;
#(
    parameter int DW  = 40,
    parameter int IXW = 6
) (
    input  logic [3:0]     op,
    input  logic           sat,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [IXW-1:0] idx,
    output logic [DW-1:0]  res,
    output logic           v_out
);
    localparam logic [DW-1:0] WMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] WMIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] mask;
    logic [DW-1:0] mag;
    logic          is_min;

    assign mask   = (int'(idx) < DW) ? (ONE << idx) : '0;
    assign is_min = (a == WMIN);
    assign mag    = a[DW-1] ? (~a + ONE) : a;

    always_comb begin
        v_out = 1'b0;
        unique case (op_e'(op))
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            OP_ABS: begin
                v_out = is_min;
                res   = (is_min && sat) ? WMAX : mag;
            end
            OP_BSET: res = a | mask;
            OP_BCLR: res = a & ~mask;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/dalu_core.sv
module dalu_core
    import dalu_pkg::*;
#(
    parameter int DW  = dalu_pkg::DW,
    parameter int HW  = dalu_pkg::HW,
    parameter int IXW = dalu_pkg::IXW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [3:0]     op,
    input  logic           dual,
    input  logic           sat_en,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic [IXW-1:0] bit_idx,
    output logic           out_valid,
    output logic [DW-1:0]  result,
    output logic           carry,
    output logic           ovf,
    output logic           zero,
    output logic           lt
);
    logic [DW-1:0] ar_res, un_res;
    logic          ar_c, ar_v, ar_neg, un_v;
    logic [DW-1:0] n_res;
    logic          n_c, n_v, n_z, n_lt;

    dalu_arith #(.DW(DW), .HW(HW)) u_arith (
        .a(a), .b(b), .sub(op != OP_ADD), .dual(dual), .sat(sat_en),
        .res(ar_res), .c_out(ar_c), .v_out(ar_v), .neg(ar_neg)
    );

    dalu_unary #(.DW(DW), .IXW(IXW)) u_unary (
        .op(op), .sat(sat_en), .a(a), .b(b), .idx(bit_idx),
        .res(un_res), .v_out(un_v)
    );

    always_comb begin
        n_res = un_res;
        n_c   = 1'b0;
        n_v   = un_v;
        n_lt  = 1'b0;
        n_z   = (un_res == '0);
        unique case (op_e'(op))
            OP_ADD, OP_SUB, OP_CMP: begin
                n_res = (op == OP_CMP) ? result : ar_res;
                n_c   = ar_c;
                n_v   = ar_v;
                n_lt  = ar_neg;
                n_z   = (ar_res == '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            carry     <= 1'b0;
            ovf       <= 1'b0;
            zero      <= 1'b0;
            lt        <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= n_res;
                carry  <= n_c;
                ovf    <= n_v;
                zero   <= n_z;
                lt     <= n_lt;
            end
        end
    end
endmodule

// File: rtl/dalu_chk.sv
module dalu_chk #(
    parameter int DW  = 40,
    parameter int HW  = 16,
    parameter int IXW = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [3:0]     op,
    input logic           dual,
    input logic           sat_en,
    input logic [DW-1:0]  a,
    input logic [DW-1:0]  b,
    input logic [IXW-1:0] bit_idx,
    input logic           out_valid,
    input logic [DW-1:0]  result,
    input logic           carry,
    input logic           ovf,
    input logic           zero,
    input logic           lt
);
    localparam int TW = DW - 2*HW;
    localparam logic [DW-1:0] WMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] WMIN = {1'b1, {(DW-1){1'b0}}};

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result) && $stable(zero));
    a_r2_add_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == 4'd0 && !dual && a == '0 |=> result == $past(b) && !ovf);
    a_r4_lane_sext: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && dual && op <= 4'd1 |=> result[DW-1:2*HW] == {TW{result[2*HW-1]}});
    a_r5_sat_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && sat_en && !dual && op <= 4'd1 |=> !ovf || result == WMAX || result == WMIN);
    a_r6_cmp_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == 4'd2 |=> $stable(result));
    a_r7_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op >= 4'd3 && op <= 4'd6 |=> !carry && !ovf && !lt);
    a_r9_idx_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (op == 4'd8 || op == 4'd9) && int'(bit_idx) >= DW |=> result == $past(a));
    a_r10_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op != 4'd2 |=> zero == (result == '0));
endmodule

bind dalu_core dalu_chk #(.DW(DW), .HW(HW), .IXW(IXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .dual(dual),
    .sat_en(sat_en), .a(a), .b(b), .bit_idx(bit_idx), .out_valid(out_valid),
    .result(result), .carry(carry), .ovf(ovf), .zero(zero), .lt(lt)
);

// File: tb/dalu_core_bench.sv
`timescale 1ns/1ps
module dalu_core_bench;
    localparam logic [39:0] MAXV = 40'h7F_FFFF_FFFF;
    localparam logic [39:0] MINV = 40'h80_0000_0000;

    typedef struct {
        logic [39:0] r;
        logic c, v, z, lt;
        string tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, dual = 1'b0, sat_en = 1'b0;
    logic [3:0] op = 4'd0;
    logic [39:0] a = '0, b = '0;
    logic [5:0] bit_idx = '0;
    logic out_valid, carry, ovf, zero, lt;
    logic [39:0] result;

    int checks = 0, errors = 0;
    exp_t q[$];
    exp_t last;

    always #2.5 clk = ~clk;

    dalu_core u_dalu_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .dual(dual),
        .sat_en(sat_en), .a(a), .b(b), .bit_idx(bit_idx), .out_valid(out_valid),
        .result(result), .carry(carry), .ovf(ovf), .zero(zero), .lt(lt)
    );

    function automatic exp_t model(logic [3:0] o, logic dl, logic st, logic [39:0] x,
                                   logic [39:0] y, logic [5:0] ix, logic [39:0] prev);
        exp_t e;
        logic [16:0] u16;
        logic [40:0] u40;
        int sl, sh;
        longint sw;
        logic [15:0] rl, rh;
        logic vl, vh;
        e.r = x; e.c = 0; e.v = 0; e.lt = 0;
        if (o <= 4'd2) begin
            if (dl) begin
                if (o == 4'd0) begin
                    sl = int'($signed(x[15:0])) + int'($signed(y[15:0]));
                    sh = int'($signed(x[31:16])) + int'($signed(y[31:16]));
                    u16 = {1'b0, x[31:16]} + {1'b0, y[31:16]};
                    e.c = u16[16];
                end else begin
                    sl = int'($signed(x[15:0])) - int'($signed(y[15:0]));
                    sh = int'($signed(x[31:16])) - int'($signed(y[31:16]));
                    e.c = (x[31:16] >= y[31:16]);
                end
                vl = (sl > 32767) || (sl < -32768);
                vh = (sh > 32767) || (sh < -32768);
                rl = (vl && st) ? ((sl < 0) ? 16'h8000 : 16'h7FFF) : sl[15:0];
                rh = (vh && st) ? ((sh < 0) ? 16'h8000 : 16'h7FFF) : sh[15:0];
                e.r = {{8{rh[15]}}, rh, rl};
                e.v = vl | vh;
                e.lt = (sh < 0);
            end else begin
                if (o == 4'd0) begin
                    sw = longint'($signed(x)) + longint'($signed(y));
                    u40 = {1'b0, x} + {1'b0, y};
                    e.c = u40[40];
                end else begin
                    sw = longint'($signed(x)) - longint'($signed(y));
                    e.c = (x >= y);
                end
                e.v = (sw > 64'sh7F_FFFF_FFFF) || (sw < -64'sh80_0000_0000);
                e.r = (e.v && st) ? ((sw < 0) ? MINV : MAXV) : sw[39:0];
                e.lt = (sw < 0);
            end
            e.z = (e.r == '0);
            if (o == 4'd2) e.r = prev;
            return e;
        end
        case (o)
            4'd3: e.r = x & y;
            4'd4: e.r = x | y;
            4'd5: e.r = x ^ y;
            4'd6: e.r = ~x;
            4'd7: begin
                if (x == MINV) begin
                    e.v = 1;
                    e.r = st ? MAXV : MINV;
                end else begin
                    e.r = x[39] ? (40'd0 - x) : x;
                end
            end
            4'd8: if (ix < 6'd40) e.r[ix] = 1'b1;
            4'd9: if (ix < 6'd40) e.r[ix] = 1'b0;
            default: e.r = x;
        endcase
        e.z = (e.r == '0);
        return e;
    endfunction

    task automatic compare(exp_t e, string where);
        checks++;
        if (result !== e.r || carry !== e.c || ovf !== e.v || zero !== e.z || lt !== e.lt) begin
            errors++;
            $display("FAIL %s %s: got r=%h c%0b v%0b z%0b lt%0b exp r=%h c%0b v%0b z%0b lt%0b",
                     e.tag, where, result, carry, ovf, zero, lt, e.r, e.c, e.v, e.z, e.lt);
        end
    endtask

    task automatic issue(logic [3:0] o, logic dl, logic st, logic [39:0] x,
                         logic [39:0] y, logic [5:0] ix, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; op = o; dual = dl; sat_en = st; a = x; b = y; bit_idx = ix;
        e = model(o, dl, st, x, y, ix, last.r);
        e.tag = tag;
        last = e;
        q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op = 4'($urandom_range(0, 15));
            a = {8'($urandom), 32'($urandom)};
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R1: out_valid=1 with nothing outstanding, expected 0");
            end else begin
                compare(q.pop_front(), "scoreboard");
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        last.r = '0; last.c = 0; last.v = 0; last.z = 0; last.lt = 0; last.tag = "R1 reset";
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        compare(last, "reset state");
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_valid after reset got %0b expected 0", out_valid);
        end
        rst_n = 1'b1;

        issue(4'd0, 0, 0, 40'h00_0000_1234, 40'h00_0000_4321, 0, "R2 plain add");
        issue(4'd0, 0, 0, 40'hFF_FFFF_FFFF, 40'h1, 0, "R2 carry out of bit 39 R10 zero");
        issue(4'd1, 0, 0, 40'h5, 40'h9, 0, "R2 subtract with borrow R10 lt");
        issue(4'd1, 0, 0, 40'h9, 40'h5, 0, "R2 subtract no borrow");
        issue(4'd0, 0, 0, MAXV, 40'h1, 0, "R3 overflow wraps");
        issue(4'd0, 0, 1, MAXV, 40'h1, 0, "R5 positive clamp");
        issue(4'd1, 0, 1, MINV, 40'h1, 0, "R5 negative clamp");
        issue(4'd0, 0, 0, 40'h00_0000_0777, 40'h00_0000_0111, 0, "R2 result before compare");
        issue(4'd2, 0, 0, 40'h30, 40'h30, 0, "R6 compare equal keeps result");
        issue(4'd2, 0, 0, 40'h10, 40'h30, 0, "R6 compare less keeps result");
        issue(4'd2, 0, 0, MINV, 40'h1, 0, "R6 compare overflow");
        issue(4'd0, 1, 0, 40'h00_0001_FFFF, 40'h00_0000_0001, 0, "R4 no carry across bit 16");
        issue(4'd0, 1, 0, 40'h00_7FFF_0001, 40'h00_0001_0001, 0, "R4 upper lane sign extends");
        issue(4'd1, 1, 0, 40'h00_0003_0000, 40'h00_0004_0001, 0, "R4 lane subtract");
        issue(4'd0, 1, 1, 40'h00_7FFF_8000, 40'h00_0001_FFFF, 0, "R5 both lanes clamp");
        issue(4'd2, 1, 0, 40'h00_0002_0005, 40'h00_0002_0005, 0, "R4 R6 lane compare");
        issue(4'd3, 0, 0, 40'hF0_F0F0_F0F0, 40'hFF_00FF_00FF, 0, "R7 and");
        issue(4'd4, 1, 0, 40'h0F_0000_000F, 40'h00_F000_F000, 0, "R7 or R11 dual ignored");
        issue(4'd5, 0, 0, 40'hAA_AAAA_AAAA, 40'hAA_AAAA_AAAA, 0, "R7 xor to zero");
        issue(4'd6, 0, 0, 40'h00_FFFF_0000, 40'h0, 0, "R7 invert");
        issue(4'd7, 0, 0, 40'hFF_FFFF_FFFB, 40'h0, 0, "R8 abs negative");
        issue(4'd7, 0, 1, MINV, 40'h0, 0, "R8 abs min saturates");
        issue(4'd7, 0, 0, MINV, 40'h0, 0, "R8 abs min wraps");
        issue(4'd8, 0, 0, 40'h0, 40'h0, 6'd0, "R9 set bit 0");
        issue(4'd8, 1, 0, 40'h0, 40'h0, 6'd39, "R9 set bit 39 R11");
        issue(4'd9, 0, 0, 40'hFF_FFFF_FFFF, 40'h0, 6'd5, "R9 clear bit 5");
        issue(4'd8, 0, 0, 40'h12_3456_789A, 40'h0, 6'd40, "R9 index 40 unchanged");
        issue(4'd9, 0, 0, 40'h12_3456_789A, 40'h0, 6'd63, "R9 index 63 unchanged");
        issue(4'd12, 1, 1, 40'h00_CAFE_0000, 40'h1, 0, "R11 spare code passes a");
        idle(2);
        wait (q.size() == 0);
        @(negedge clk); #1;
        compare(last, "R1 hold after idle");

        for (int i = 0; i < 80; i++) begin
            logic [39:0] ra, rb;
            ra = {8'($urandom), 32'($urandom)};
            rb = {8'($urandom), 32'($urandom)};
            if (i % 4 == 0) ra[38:0] = '1;
            issue(4'($urandom_range(0, 11)), 1'($urandom), 1'($urandom), ra, rb,
                  6'($urandom), "R2 R4 R10 mixed stream");
            if (i % 9 == 0) idle(1);
        end
        idle(2);
        wait (q.size() == 0);
        @(negedge clk); #1;
        compare(last, "R1 hold at end");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule